// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 64-bit effective address of a memory operand from the fields that the decoder has already extracted. Its inputs are a base register value and an index register value, both read from a 16-entry general register file, a 2-bit scale code, a raw displacement with a width code, and an enable for each register term. The result is base plus the index scaled by a power of two, plus the sign-extended displacement. The sum wraps modulo 2^64. No segment base is added, so the address space is flat.

The register number of the index operand is checked. Register 4 holds the stack pointer and may never act as an index. When it is named as the index, its term is dropped and a fault is flagged. An unused displacement width code is also flagged as a fault. Each request is marked by an input valid strobe. The address and fault flag are registered and appear one cycle later with a one-cycle valid pulse. Translation and the memory access itself are left to later stages.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset, out_vld, out_addr and out_fault are all zero.
- R2: out_vld is high in exactly the cycle after one in which in_vld was sampled high, and low otherwise.
- R3: out_addr equals base + (index << scale_code) + displacement modulo 2^64. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R4: Width code 0 sign-extends disp_raw[7:0], code 1 sign-extends disp_raw[15:0], and code 2 sign-extends disp_raw[31:0]. Raw bits above the selected width have no effect.
- R5: Width code 3 is illegal. The displacement term is then zero and out_fault is set.
- R6: With idx_en high and idx_num equal to 4, the index term is zero and out_fault is set.
- R7: With base_en low, the base term is zero. With idx_en low, the index term is zero and idx_num raises no fault.
- R8: Carries out of bit 63 are discarded, so the sum wraps both upward and downward.
- R9: When in_vld is low, out_addr and out_fault keep their values from the previous cycle.
- R10: out_fault is low for any request with a legal width code and no stack-pointer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| base_en | input | 1 | Base term present |
| base_val | input | 64 | Base register value |
| idx_en | input | 1 | Index term present |
| idx_num | input | 4 | Index register number |
| idx_val | input | 64 | Index register value |
| scale_code | input | 2 | Index shift amount, 0 to 3 |
| disp_raw | input | 32 | Raw displacement bits |
| disp_width | input | 2 | Displacement width code (0: 8, 1: 16, 2: 32, 3: illegal) |
| out_vld | output | 1 | Result valid pulse |
| out_addr | output | 64 | Effective address |
| out_fault | output | 1 | Illegal encoding flag |

## Verification
The bench loads the upper raw displacement bits with junk while a narrow width is selected. A design that extended from the wrong bit position, or zero-extended, would produce an address off by whole multiples of 256 or 65536. It names register 4 as the index both with the index enabled and with it disabled. A design that masked on the number alone would raise a false fault, and one that ignored the number would add the stack pointer in. It also drives sums that cross zero in both directions and all four scale codes, which exposes a misplaced shift. Idle cycles after a result catch an output register that loads without the strobe.

// File: rtl/agu_pkg.sv
// Package: shared widths and encodings for the effective address generator.
// Assumes: displacement field is at most 32 bits and the register file has 16 entries.
package agu_pkg;
    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned DISP_W   = 32;
    localparam int unsigned RNUM_W   = 4;
    localparam int unsigned SP_NUM   = 4;

    typedef enum logic [1:0] {
        DW_8   = 2'b00,
        DW_16  = 2'b01,
        DW_32  = 2'b10,
        DW_BAD = 2'b11
    } disp_width_e;
endpackage

// File: rtl/agu_disp_ext.sv
// Module: agu_disp_ext
// Sign-extends an 8, 16 or 32 bit displacement to the address width.
// Assumes: DISP_W >= 32; width code 3 is illegal, gives zero and raises bad.
module agu_disp_ext
    import agu_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DISP_W
) (
    input  logic [DW-1:0] disp_raw,
    input  logic [1:0]    width,
    output logic [AW-1:0] disp_ext,
    output logic          bad
);
    localparam int unsigned PAD8  = AW - 8;
    localparam int unsigned PAD16 = AW - 16;
    localparam int unsigned PAD32 = AW - 32;

    // Pick the active slice and replicate its sign bit upward.
    always_comb begin
        bad = 1'b0;
        unique case (disp_width_e'(width))
            DW_8:    disp_ext = {{PAD8{disp_raw[7]}},   disp_raw[7:0]};
            DW_16:   disp_ext = {{PAD16{disp_raw[15]}}, disp_raw[15:0]};
            DW_32:   disp_ext = {{PAD32{disp_raw[31]}}, disp_raw[31:0]};
            default: begin
                disp_ext = '0;
                bad      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/agu_index_term.sv
// Module: agu_index_term
// Produces the scaled index term and flags a stack-pointer index.
// Assumes: scale is a left shift of 0..3; a disabled index is never a fault.
module agu_index_term
    import agu_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NW = RNUM_W,
    parameter int unsigned SP = SP_NUM
) (
    input  logic          idx_en,
    input  logic [NW-1:0] idx_num,
    input  logic [AW-1:0] idx_val,
    input  logic [1:0]    scale_code,
    output logic [AW-1:0] idx_term,
    output logic          sp_fault
);
    localparam logic [NW-1:0] SP_CODE = NW'(SP);

    logic use_idx;

    // Decide whether the index participates and whether it is illegal.
    always_comb begin
        sp_fault = idx_en && (idx_num == SP_CODE);
        use_idx  = idx_en && !sp_fault;
    end

    // Scale by shifting and gate the term when it is absent.
    always_comb begin
        idx_term = use_idx ? (idx_val << scale_code) : '0;
    end
endmodule

// File: rtl/agu_addr_gen.sv
// Module: agu_addr_gen (top)
// Adds base, scaled index and sign-extended displacement into a flat 64-bit
// address, registered one cycle after in_vld with a valid pulse and fault flag.
// Assumes: operand values are already read from the register file.
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DISP_W,
    parameter int unsigned NW = RNUM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          base_en,
    input  logic [63:0]   base_val,
    input  logic          idx_en,
    input  logic [3:0]    idx_num,
    input  logic [63:0]   idx_val,
    input  logic [1:0]    scale_code,
    input  logic [31:0]   disp_raw,
    input  logic [1:0]    disp_width,
    output logic          out_vld,
    output logic [63:0]   out_addr,
    output logic          out_fault
);
    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] sum_nxt;
    logic          sp_fault;
    logic          disp_bad;

    agu_index_term #(.AW(AW), .NW(NW), .SP(SP_NUM)) u_idx (
        .idx_en    (idx_en),
        .idx_num   (idx_num),
        .idx_val   (idx_val),
        .scale_code(scale_code),
        .idx_term  (idx_term),
        .sp_fault  (sp_fault)
    );

    agu_disp_ext #(.AW(AW), .DW(DW)) u_disp (
        .disp_raw(disp_raw),
        .width   (disp_width),
        .disp_ext(disp_term),
        .bad     (disp_bad)
    );

    // Gate the base term and form the wrapping three-way sum.
    always_comb begin
        base_term = base_en ? base_val : '0;
        sum_nxt   = base_term + idx_term + disp_term;
    end

    // Output register: load on a request, hold otherwise, pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_addr  <= '0;
            out_fault <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_addr  <= sum_nxt;
                out_fault <= sp_fault || disp_bad;
            end
        end
    end

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_addr) && $stable(out_fault)));
    // R6
    sp_index_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && idx_en && idx_num == 4'd4) |=> out_fault);
    // R5
    bad_width_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && disp_width == 2'b11) |=> out_fault);
    // R10
    legal_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && disp_width != 2'b11 && !(idx_en && idx_num == 4'd4)) |=> !out_fault);
    // R4
    disp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !base_en && !idx_en && disp_width == 2'b10)
        |=> out_addr == {{32{$past(disp_raw[31])}}, $past(disp_raw)});
endmodule

// File: tb/test_agu_addr_gen.sv
`timescale 1ns/1ps
module test_agu_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        base_en = 1'b0;
    logic [63:0] base_val = '0;
    logic        idx_en = 1'b0;
    logic [3:0]  idx_num = '0;
    logic [63:0] idx_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp_raw = '0;
    logic [1:0]  disp_width = '0;
    logic        out_vld;
    logic [63:0] out_addr;
    logic        out_fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    agu_addr_gen i_agu_addr_gen (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .base_en(base_en), .base_val(base_val),
        .idx_en(idx_en), .idx_num(idx_num), .idx_val(idx_val),
        .scale_code(scale_code), .disp_raw(disp_raw), .disp_width(disp_width),
        .out_vld(out_vld), .out_addr(out_addr), .out_fault(out_fault)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected address per R3/R4/R5/R6/R7, using multiplication rather than shifts.
    function automatic logic [63:0] model(input logic be, input logic [63:0] b,
        input logic ie, input logic [3:0] inum, input logic [63:0] iv,
        input logic [1:0] sc, input logic [31:0] d, input logic [1:0] w);
        logic [63:0] dt;
        logic [63:0] it;
        logic [63:0] mul;
        case (sc)
            2'd0: mul = 64'd1;
            2'd1: mul = 64'd2;
            2'd2: mul = 64'd4;
            default: mul = 64'd8;
        endcase
        case (w)
            2'd0: dt = 64'($signed(d[7:0]));
            2'd1: dt = 64'($signed(d[15:0]));
            2'd2: dt = 64'($signed(d));
            default: dt = 64'd0;
        endcase
        it = (ie && inum != 4'd4) ? iv * mul : 64'd0;
        return (be ? b : 64'd0) + it + dt;
    endfunction

    // Drive one request, then check the registered result one cycle later.
    task automatic run(input string req, input logic be, input logic [63:0] b,
        input logic ie, input logic [3:0] inum, input logic [63:0] iv,
        input logic [1:0] sc, input logic [31:0] d, input logic [1:0] w,
        input logic exp_fault);
        @(negedge clk);
        in_vld = 1'b1; base_en = be; base_val = b; idx_en = ie; idx_num = inum;
        idx_val = iv; scale_code = sc; disp_raw = d; disp_width = w;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
        check64({req, " R2 vld"}, {63'd0, out_vld}, 64'd1);
        check64({req, " addr"}, out_addr, model(be, b, ie, inum, iv, sc, d, w));
        check64({req, " fault"}, {63'd0, out_fault}, {63'd0, exp_fault});
    endtask

    task automatic t_reset();
        check64("R1 vld", {63'd0, out_vld}, 64'd0);
        check64("R1 addr", out_addr, 64'd0);
        check64("R1 fault", {63'd0, out_fault}, 64'd0);
    endtask

    task automatic t_scales();
        for (int s = 0; s < 4; s++)
            run("R3 scale", 1'b1, 64'h1000, 1'b1, 4'd3, 64'h10, 2'(s), 32'h0000_00F0, 2'd0, 1'b0);
        run("R3 mixed", 1'b1, 64'h0000_7FFF_0000_0000, 1'b1, 4'd12, 64'h1234_5678, 2'd3,
            32'h0000_0100, 2'd1, 1'b0);
    endtask

    task automatic t_widths();
        run("R4 w8", 1'b1, 64'h8000, 1'b0, 4'd0, 64'h0, 2'd0, 32'hABCD_1280, 2'd0, 1'b0);
        run("R4 w16", 1'b1, 64'h0, 1'b0, 4'd0, 64'h0, 2'd0, 32'h1234_8001, 2'd1, 1'b0);
        run("R4 w32", 1'b0, 64'h55, 1'b0, 4'd0, 64'h0, 2'd0, 32'h7FFF_FFFF, 2'd2, 1'b0);
        run("R4 w32neg", 1'b0, 64'h0, 1'b0, 4'd0, 64'h0, 2'd0, 32'h8000_0000, 2'd2, 1'b0);
    endtask

    task automatic t_illegal();
        run("R5 badw", 1'b1, 64'h4000, 1'b1, 4'd2, 64'h8, 2'd1, 32'hFFFF_FFFF, 2'd3, 1'b1);
        run("R6 spidx", 1'b1, 64'h2000, 1'b1, 4'd4, 64'h100, 2'd2, 32'h0000_0010, 2'd0, 1'b1);
    endtask

    task automatic t_absent();
        run("R7 idxoff_sp", 1'b1, 64'h3000, 1'b0, 4'd4, 64'hFFFF, 2'd1, 32'h4, 2'd0, 1'b0);
        run("R7 baseoff", 1'b0, 64'hDEAD_BEEF, 1'b1, 4'd15, 64'h20, 2'd2, 32'h0, 2'd0, 1'b0);
        run("R10 legal", 1'b1, 64'h10, 1'b1, 4'd5, 64'h1, 2'd0, 32'h1, 2'd2, 1'b0);
    endtask

    task automatic t_wrap();
        run("R8 up", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'd8, 64'h1, 2'd0, 32'h0, 2'd0, 1'b0);
        run("R8 down", 1'b1, 64'h0, 1'b0, 4'd0, 64'h0, 2'd0, 32'h0000_00FF, 2'd0, 1'b0);
        run("R8 big", 1'b1, 64'hF000_0000_0000_0000, 1'b1, 4'd9, 64'h2000_0000_0000_0001,
            2'd3, 32'h0, 2'd2, 1'b0);
    endtask

    task automatic t_hold();
        logic [63:0] a;
        run("R9 setup", 1'b1, 64'h0, 1'b1, 4'd4, 64'h0, 2'd0, 32'h77, 2'd0, 1'b1);
        a = out_addr;
        @(negedge clk);
        base_val = 64'h1111; base_en = 1'b1; idx_num = 4'd1; disp_width = 2'd2;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check64("R9 addr hold", out_addr, a);
            check64("R9 fault hold", {63'd0, out_fault}, 64'd1);
            check64("R2 idle", {63'd0, out_vld}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_scales();
        t_widths();
        t_illegal();
        t_absent();
        t_wrap();
        t_hold();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule